// File: doc/BRIEF.md
# Phase-Continuous FFSK Tone Transmitter

This block turns a serial bit stream into a fast frequency-shift-keyed tone, delivered as a stream of 8-bit offset-binary sine amplitude codes that a downstream DAC converts to audio. The tone is built from a pseudo-sine of 140 amplitude steps per full cycle. A mark bit (1) and a space bit (0) each carry a fixed fraction of a tone cycle. Every bit starts and ends at a zero crossing, and the step index carries across bit boundaries, so the waveform never jumps in phase.

The block runs from either a 1.008 MHz or a 4.032 MHz master clock, selected by `mclk_fast`. Two select inputs choose 1200, 2400 or 4800 baud. The block drives a sync square wave at the bit rate, and the data source presents each new bit while that wave is high. An active-low enable puts the block into powersave when it is high. In powersave, `sine_valid` stands in for the high-impedance state of an analogue output.

Top module: `ffsk_tx`

## Requirements
- R1: The baud rate is decoded from the select inputs as follows. With `sel_low_baud`=1 the rate is 1200 baud on either clock. With `sel_low_baud`=0 and `mclk_fast`=1, `sel_top_baud`=1 gives 4800 baud and `sel_top_baud`=0 gives 2400 baud. With `sel_low_baud`=0 and `mclk_fast`=0 the rate is 2400 baud.
- R2: When `mclk_fast`=0, `sel_top_baud` has no effect, so 4800 baud is reachable only on the fast clock.
- R3: A bit lasts the following number of master clocks. On the slow clock: 840 at 1200 baud and 420 at 2400 baud. On the fast clock: 3360 at 1200 baud, 1680 at 2400 baud and 840 at 4800 baud. `tx_sync` is 0 for the first half of each bit and 1 for the second half, and its falling edge marks the start of a bit.
- R4: During one bit, the step index advances at evenly spaced clocks by the following counts. At 1200 baud: 140 for a mark and 210 for a space. At 2400 and 4800 baud: 70 for a mark and 140 for a space.
- R5: The step index carries across bit boundaries, so every bit begins at index 0 or 70, where `sine_code` is 128.
- R6: `sine_code` equals 128 + round(127·sin(2π·i/140)) within ±1 code, where i is the current step index (0..139).
- R7: `tx_data` is sampled only at the clock edge that starts a bit. Changes at any other time do not affect the output.
- R8: When `tx_en_n`=1 at a clock edge, then from that edge `sine_valid`=0, `tx_sync`=1 and `sine_code`=128. The next enable starts a fresh bit at index 0.
- R9: After reset, `sine_valid`=0, `tx_sync`=1 and `sine_code`=128.
- R10: The rate and clock-rate selects are captured at the start of each bit. A change in mid-bit takes effect from the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (1.008 MHz or 4.032 MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk_fast | input | 1 | 1 = master clock is 4.032 MHz, 0 = 1.008 MHz |
| sel_low_baud | input | 1 | 1 = 1200 baud; 0 = 2400 or 4800 baud |
| sel_top_baud | input | 1 | With `sel_low_baud`=0 on the fast clock, selects 4800 baud |
| tx_en_n | input | 1 | Active-low transmit enable; 1 = powersave |
| tx_data | input | 1 | Serial bit to transmit, sampled at bit start |
| tx_sync | output | 1 | Bit-rate square wave; falling edge starts a bit |
| sine_code | output | 8 | Offset-binary sine amplitude code |
| sine_valid | output | 1 | 1 while transmitting; 0 stands for a disabled output |

## Verification
On the last prescaled tick of a bit, the step advance and the bit boundary fall in the same cycle. That cycle loads the new bit and new rate and moves the index to 0 or 70. The bench provokes this at every bit of mark/space streams in all five rate settings, including streams whose rate and clock selects change in mid-bit. At each boundary it expects exactly midscale, and on every other cycle it compares the code against its own index model. Disabling in mid-bit and disabling on a boundary cycle are also covered, and the bench checks that the next enable restarts at index 0.

// File: rtl/ffsk_pkg.sv
// Shared types and elaboration-time helpers for the FFSK transmitter.
// Assumes integer arithmetic only; helpers are evaluated on constants.
package ffsk_pkg;

    typedef enum logic [1:0] {
        BAUD_1200 = 2'd0,
        BAUD_2400 = 2'd1,
        BAUD_4800 = 2'd2
    } baud_e;

    // Rational sine approximation for the first quarter cycle.
    // q: step within the quarter, half: steps per half cycle, peak: full scale.
    function automatic int pseudo_sin(input int q, input int half, input int peak);
        int prod;
        int num;
        int den;
        prod = q * (half - q);
        num  = peak * 16 * prod;
        den  = 5 * half * half - 4 * prod;
        return (num + den / 2) / den;
    endfunction

endpackage

// File: rtl/ffsk_rate_decode.sv
// Decodes the clock-rate and baud select inputs into a baud mode and a
// prescale flag. Assumes 4800 baud exists only on the fast master clock.
module ffsk_rate_decode
    import ffsk_pkg::*;
(
    input  logic  mclk_fast,
    input  logic  sel_low_baud,
    input  logic  sel_top_baud,
    output baud_e baud,
    output logic  use_prescale
);

    // Select the baud mode; the top select only counts on the fast clock.
    always_comb begin
        if (sel_low_baud)
            baud = BAUD_1200;
        else if (mclk_fast && sel_top_baud)
            baud = BAUD_4800;
        else
            baud = BAUD_2400;
    end

    // The fast clock is divided down unless 4800 baud uses it directly.
    always_comb use_prescale = mclk_fast && (baud != BAUD_4800);

endmodule

// File: rtl/ffsk_timebase.sv
// Bit and step timebase. A prescaler makes ticks; each bit lasts a fixed
// number of ticks; the sine step index advances every P ticks, P set by
// the latched baud and bit value. Assumes the step period divides the bit
// length, so every bit ends on a step and at a zero crossing.
module ffsk_timebase
    import ffsk_pkg::*;
#(
    parameter int BIT_TICKS = 840,
    parameter int STEPS     = 140,
    parameter int FAST_DIV  = 4,
    localparam int IDX_W    = $clog2(STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  baud_e            baud,
    input  logic             use_prescale,
    input  logic             data,
    output logic [IDX_W-1:0] step_idx,
    output logic             active,
    output logic             sync
);

    localparam int HALF_TICKS   = BIT_TICKS / 2;
    localparam int P_1200_MARK  = BIT_TICKS / STEPS;
    localparam int P_1200_SPACE = (2 * BIT_TICKS) / (3 * STEPS);
    localparam int P_2400_MARK  = (2 * HALF_TICKS) / STEPS;
    localparam int P_2400_SPACE = HALF_TICKS / STEPS;
    localparam int P_4800_MARK  = (2 * BIT_TICKS) / STEPS;
    localparam int P_4800_SPACE = BIT_TICKS / STEPS;
    localparam int DIV_W        = $clog2(P_4800_MARK + 1);
    localparam int BIT_W        = $clog2(BIT_TICKS);
    localparam int PRE_W        = $clog2(FAST_DIV);

    logic             active_q;
    baud_e            baud_q;
    logic             pre_q;
    logic             bit_q;
    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic [BIT_W-1:0] bit_cnt;
    logic [IDX_W-1:0] idx_q;

    logic             tick;
    logic [BIT_W-1:0] bit_last;
    logic [BIT_W-1:0] bit_half;
    logic [DIV_W-1:0] step_last;
    logic             step_wrap;
    logic             bit_end;
    logic             bit_start;
    logic [IDX_W-1:0] idx_next;

    // Prescaler tick: every clock, or every FAST_DIV clocks when prescaled.
    always_comb tick = !pre_q || (pre_cnt == PRE_W'(FAST_DIV - 1));

    // Bit length and half length in ticks for the latched mode.
    always_comb begin
        if (baud_q == BAUD_2400) begin
            bit_last = BIT_W'(HALF_TICKS - 1);
            bit_half = BIT_W'(HALF_TICKS / 2);
        end else begin
            bit_last = BIT_W'(BIT_TICKS - 1);
            bit_half = BIT_W'(HALF_TICKS);
        end
    end

    // Ticks per sine step for the latched mode and bit value.
    always_comb begin
        unique case (baud_q)
            BAUD_2400: step_last = DIV_W'((bit_q ? P_2400_MARK : P_2400_SPACE) - 1);
            BAUD_4800: step_last = DIV_W'((bit_q ? P_4800_MARK : P_4800_SPACE) - 1);
            default:   step_last = DIV_W'((bit_q ? P_1200_MARK : P_1200_SPACE) - 1);
        endcase
    end

    // Step and bit events, and the start of a new bit.
    always_comb begin
        step_wrap = active_q && tick && (div_cnt == step_last);
        bit_end   = active_q && tick && (bit_cnt == bit_last);
        bit_start = run && (!active_q || bit_end);
        idx_next  = (idx_q == IDX_W'(STEPS - 1)) ? '0 : idx_q + 1'b1;
    end

    // Sequential timebase: powersave clears all state, bit start reloads.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            active_q <= 1'b0;
            baud_q   <= BAUD_1200;
            pre_q    <= 1'b0;
            bit_q    <= 1'b0;
            pre_cnt  <= '0;
            div_cnt  <= '0;
            bit_cnt  <= '0;
            idx_q    <= '0;
        end else begin
            active_q <= 1'b1;
            if (step_wrap)
                idx_q <= idx_next;
            if (bit_start) begin
                baud_q  <= baud;
                pre_q   <= use_prescale;
                bit_q   <= data;
                pre_cnt <= '0;
                div_cnt <= '0;
                bit_cnt <= '0;
            end else begin
                pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
                if (tick) begin
                    div_cnt <= step_wrap ? '0 : div_cnt + 1'b1;
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // Outputs: sync is low in the first half of a bit and high when idle.
    always_comb begin
        step_idx = idx_q;
        active   = active_q;
        sync     = active_q ? (bit_cnt >= bit_half) : 1'b1;
    end

endmodule

// File: rtl/ffsk_sine_lut.sv
// Maps a step index (0..STEPS-1) to an offset-binary sine code. Only one
// quarter cycle is tabulated; the other three are folded onto it.
// Assumes STEPS is a multiple of four.
module ffsk_sine_lut
    import ffsk_pkg::*;
#(
    parameter int STEPS    = 140,
    parameter int AMP_W    = 8,
    localparam int IDX_W   = $clog2(STEPS),
    localparam int QTR     = STEPS / 4,
    localparam int HALF    = STEPS / 2,
    localparam int Q_W     = $clog2(QTR + 1),
    localparam int MAG_W   = AMP_W - 1,
    localparam int PEAK    = (1 << MAG_W) - 1
) (
    input  logic [IDX_W-1:0] idx,
    output logic [AMP_W-1:0] code
);

    logic [MAG_W-1:0] mag_tab [QTR+1];
    logic [Q_W-1:0]   q_sel;
    logic             neg;
    logic [MAG_W-1:0] mag;

    // Quarter-cycle magnitude table computed at elaboration.
    for (genvar g = 0; g <= QTR; g++) begin : g_tab
        assign mag_tab[g] = MAG_W'(pseudo_sin(g, HALF, PEAK));
    end

    // Fold the index onto the first quarter and note the sign.
    always_comb begin
        if (idx < IDX_W'(QTR))
            q_sel = Q_W'(idx);
        else if (idx < IDX_W'(HALF))
            q_sel = Q_W'(IDX_W'(HALF) - idx);
        else if (idx < IDX_W'(HALF + QTR))
            q_sel = Q_W'(idx - IDX_W'(HALF));
        else
            q_sel = Q_W'(IDX_W'(STEPS) - idx);
        neg = (idx >= IDX_W'(HALF));
    end

    // Offset the signed magnitude around midscale.
    always_comb begin
        mag  = mag_tab[q_sel];
        code = neg ? (AMP_W'(1 << MAG_W) - AMP_W'(mag))
                   : (AMP_W'(1 << MAG_W) + AMP_W'(mag));
    end

endmodule

// File: rtl/ffsk_tx.sv
// FFSK transmitter top: rate decode, timebase and sine lookup. While
// disabled the code is held at midscale and sine_valid is low.
// Assumes clk is the selected master clock and the inputs are synchronous.
module ffsk_tx
    import ffsk_pkg::*;
#(
    parameter int BIT_TICKS = 840,
    parameter int STEPS     = 140,
    parameter int FAST_DIV  = 4,
    parameter int AMP_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mclk_fast,
    input  logic             sel_low_baud,
    input  logic             sel_top_baud,
    input  logic             tx_en_n,
    input  logic             tx_data,
    output logic             tx_sync,
    output logic [AMP_W-1:0] sine_code,
    output logic             sine_valid
);

    localparam int IDX_W = $clog2(STEPS);
    localparam logic [AMP_W-1:0] MIDSCALE = AMP_W'(1 << (AMP_W - 1));

    baud_e            baud;
    logic             use_prescale;
    logic [IDX_W-1:0] step_idx;
    logic             active;
    logic             sync;
    logic [AMP_W-1:0] lut_code;

    ffsk_rate_decode u_decode (
        .mclk_fast    (mclk_fast),
        .sel_low_baud (sel_low_baud),
        .sel_top_baud (sel_top_baud),
        .baud         (baud),
        .use_prescale (use_prescale)
    );

    ffsk_timebase #(
        .BIT_TICKS (BIT_TICKS),
        .STEPS     (STEPS),
        .FAST_DIV  (FAST_DIV)
    ) u_timebase (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (!tx_en_n),
        .baud         (baud),
        .use_prescale (use_prescale),
        .data         (tx_data),
        .step_idx     (step_idx),
        .active       (active),
        .sync         (sync)
    );

    ffsk_sine_lut #(
        .STEPS (STEPS),
        .AMP_W (AMP_W)
    ) u_lut (
        .idx  (step_idx),
        .code (lut_code)
    );

    // Output stage: midscale and not valid while in powersave.
    always_comb begin
        tx_sync    = sync;
        sine_valid = active;
        sine_code  = active ? lut_code : MIDSCALE;
    end

endmodule

// File: rtl/ffsk_tx_checker.sv
// Property checker for ffsk_tx, bound to every instance of the top.
module ffsk_tx_checker #(
    parameter int AMP_W     = 8,
    parameter int MAX_DELTA = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_en_n,
    input logic             tx_sync,
    input logic [AMP_W-1:0] sine_code,
    input logic             sine_valid
);

    localparam logic [AMP_W-1:0] MIDSCALE = AMP_W'(1 << (AMP_W - 1));

    // R9: the first cycle after reset is idle.
    assert_reset_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!sine_valid && tx_sync && sine_code == MIDSCALE));

    // R8: a disable seen at an edge gives the idle outputs after it.
    assert_powersave_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tx_en_n) |-> (!sine_valid && tx_sync && sine_code == MIDSCALE));

    // R5: each bit starts on a zero crossing.
    assert_bit_start_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tx_sync) && sine_valid) |-> (sine_code == MIDSCALE));

    // R6: the code never reaches the bottom code when the output is valid.
    assert_code_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sine_valid |-> (sine_code != '0));

    // R5: no phase jump; successive codes differ by at most one step.
    assert_no_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sine_valid && $past(sine_valid)) |->
            ((int'(sine_code) - int'($past(sine_code)) <= MAX_DELTA) &&
             (int'($past(sine_code)) - int'(sine_code) <= MAX_DELTA)));

endmodule

bind ffsk_tx ffsk_tx_checker #(.AMP_W(AMP_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en_n    (tx_en_n),
    .tx_sync    (tx_sync),
    .sine_code  (sine_code),
    .sine_valid (sine_valid)
);

// File: tb/ffsk_tx_test.sv
// Directed bench for ffsk_tx: one task per scenario, each with its own checks.
module ffsk_tx_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mclk_fast = 1'b0;
    logic       sel_low_baud = 1'b1;
    logic       sel_top_baud = 1'b0;
    logic       tx_en_n = 1'b1;
    logic       tx_data = 1'b0;
    logic       tx_sync;
    logic [7:0] sine_code;
    logic       sine_valid;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    ffsk_tx uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mclk_fast    (mclk_fast),
        .sel_low_baud (sel_low_baud),
        .sel_top_baud (sel_top_baud),
        .tx_en_n      (tx_en_n),
        .tx_data      (tx_data),
        .tx_sync      (tx_sync),
        .sine_code    (sine_code),
        .sine_valid   (sine_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected at most %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // Baud rule from R1/R2: 0=1200, 1=2400, 2=4800.
    function automatic int exp_baud(input logic fast, input logic s12, input logic s48);
        if (s12) return 0;
        if (fast && s48) return 2;
        return 1;
    endfunction

    function automatic int exp_pre(input logic fast, input int b);
        return (fast && b != 2) ? 4 : 1;
    endfunction

    // Bit length in master clocks (R3).
    function automatic int exp_bit_clks(input logic fast, input int b);
        return ((b == 1) ? 420 : 840) * exp_pre(fast, b);
    endfunction

    // Clocks per step from the step counts per bit (R4).
    function automatic int exp_step_clks(input logic fast, input int b, input logic d);
        int steps;
        if (b == 0) steps = d ? 140 : 210;
        else        steps = d ? 70 : 140;
        return exp_bit_clks(fast, b) / steps;
    endfunction

    function automatic int exp_code(input int idx);
        real s;
        s = $sin(2.0 * 3.14159265358979 * idx / 140.0);
        return 128 + $rtoi(s * 127.0 + ((s >= 0.0) ? 0.5 : -0.5));
    endfunction

    task automatic check_idle(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(sine_valid == 1'b0, req, "valid while idle", sine_valid, 0);
            check(tx_sync == 1'b1, req, "sync while idle", tx_sync, 1);
            check(sine_code == 8'd128, req, "code while idle", sine_code, 128);
        end
    endtask

    // Core stream driver and model. Bit i uses bits[i] and the selects at i.
    // Data and selects for the next bit are applied when sync rises.
    task automatic run_stream(input string req, input int nbits, input logic [15:0] bits,
                              input logic [15:0] fast_v, input logic [15:0] s12_v,
                              input logic [15:0] s48_v, input bit glitch,
                              input int ab_bit, input int ab_k);
        int  k;
        int  bi;
        int  base;
        int  b;
        int  blen;
        int  cstep;
        int  idx;
        int  ec;
        int  diff;
        bit  done;
        logic cur_fast;
        @(negedge clk);
        mclk_fast    = fast_v[0];
        sel_low_baud = s12_v[0];
        sel_top_baud = s48_v[0];
        tx_data      = bits[0];
        tx_en_n      = 1'b0;
        cur_fast = fast_v[0];
        b     = exp_baud(fast_v[0], s12_v[0], s48_v[0]);
        blen  = exp_bit_clks(cur_fast, b);
        cstep = exp_step_clks(cur_fast, b, bits[0]);
        k = -1; bi = 0; base = 0; done = 0;
        while (!done) begin
            @(negedge clk);
            k++;
            if (k == blen) begin
                base = (base + blen / cstep) % 140;
                bi++;
                k = 0;
                if (bi < nbits) begin
                    cur_fast = fast_v[bi];
                    b     = exp_baud(fast_v[bi], s12_v[bi], s48_v[bi]);
                    blen  = exp_bit_clks(cur_fast, b);
                    cstep = exp_step_clks(cur_fast, b, bits[bi]);
                end
            end
            check(sine_valid == 1'b1, "R8", "valid while enabled", sine_valid, 1);
            check(tx_sync == (k >= blen / 2), req, "sync phase in bit (R3)", tx_sync, int'(k >= blen / 2));
            idx = (base + k / cstep) % 140;
            if (k == 0) begin
                check(sine_code == 8'd128, "R5", "code at bit start", sine_code, 128);
            end else begin
                ec   = exp_code(idx);
                diff = int'(sine_code) - ec;
                check(diff <= 1 && diff >= -1, "R4/R6", "sine code", sine_code, ec);
            end
            if (bi == nbits) begin
                tx_en_n = 1'b1;
                done = 1;
            end else if (bi == ab_bit && k == ab_k) begin
                tx_en_n = 1'b1;
                done = 1;
            end else begin
                if (glitch && (k == blen / 4 || k == blen / 4 + 4))
                    tx_data = ~tx_data;
                if (k == blen / 2 && bi + 1 < nbits) begin
                    tx_data      = bits[bi + 1];
                    mclk_fast    = fast_v[bi + 1];
                    sel_low_baud = s12_v[bi + 1];
                    sel_top_baud = s48_v[bi + 1];
                end
            end
        end
        check_idle("R8", 4);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(sine_valid == 1'b0, "R9", "valid in reset", sine_valid, 0);
        check(tx_sync == 1'b1, "R9", "sync in reset", tx_sync, 1);
        check(sine_code == 8'd128, "R9", "code in reset", sine_code, 128);
        rst_n = 1'b1;
        check_idle("R9", 3);
    endtask

    task automatic t_slow_1200;
        run_stream("R1", 6, 16'b10_0110 ^ 16'b0, 16'h0000, 16'hFFFF, 16'h0000, 1'b0, -1, 0);
    endtask

    task automatic t_slow_2400_glitch;
        // Data toggles at a quarter bit must not alter the tone (R7).
        run_stream("R7", 5, 16'b0_1011, 16'h0000, 16'h0000, 16'h0000, 1'b1, -1, 0);
    endtask

    task automatic t_slow_ignores_top;
        run_stream("R2", 3, 16'b101, 16'h0000, 16'h0000, 16'hFFFF, 1'b0, -1, 0);
    endtask

    task automatic t_fast_1200;
        run_stream("R1", 3, 16'b110, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, -1, 0);
    endtask

    task automatic t_fast_2400;
        run_stream("R3", 4, 16'b1001, 16'hFFFF, 16'h0000, 16'h0000, 1'b0, -1, 0);
    endtask

    task automatic t_fast_4800;
        run_stream("R1", 6, 16'b01_1010, 16'hFFFF, 16'h0000, 16'hFFFF, 1'b0, -1, 0);
    endtask

    task automatic t_fast_low_wins;
        // Low-baud select has priority over the top select (R1).
        run_stream("R1", 2, 16'b01, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0, -1, 0);
    endtask

    task automatic t_rate_change;
        // Bits 0-1 slow 2400, 2-3 slow 1200, 4-5 fast 4800 (R10).
        run_stream("R10", 6, 16'b01_1001, 16'b11_0000, 16'b00_1100, 16'b11_0000,
                   1'b0, -1, 0);
    endtask

    task automatic t_disable_mid_bit;
        // Abort in mid-bit, then a fresh stream must restart at index 0 (R8).
        run_stream("R8", 3, 16'b011, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1, 133);
        check_idle("R8", 10);
        run_stream("R8", 2, 16'b10, 16'h0000, 16'h0000, 16'h0000, 1'b0, -1, 0);
    endtask

    initial begin
        t_reset();
        t_slow_1200();
        t_slow_2400_glitch();
        t_slow_ignores_top();
        t_fast_1200();
        t_fast_2400();
        t_fast_4800();
        t_fast_low_wins();
        t_rate_change();
        t_disable_mid_bit();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule